// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between an integer execute stage and a 32-bit little-endian data memory. Each cycle it may accept one instruction word together with the values of its base and source registers. It recognises the base-ISA load and store encodings and adds the sign-extended 12-bit offset to the base register to form the effective address. It then issues one registered memory request that carries a word address, a per-byte write/read enable mask and store data that has already been steered into the addressed byte lanes.

The request appears one cycle after the instruction is accepted. The memory answers a load in that same cycle with a full word. From that word the unit picks the addressed byte, halfword or word and extends it to 32 bits, with sign or zero fill as the instruction asks. A halfword at an odd address, or a word that is not 4-byte aligned, is never split into two accesses. Such an access only raises a flag, and no request goes out.

Top module: `lsu_lane_align`

## Requirements
- R1: An instruction is recognised only with opcode bits [6:0] = 0000011 (load; funct3 in bits [14:12] = 000 signed byte, 001 signed half, 010 word, 100 unsigned byte, 101 unsigned half) or 0100011 (store; funct3 000 byte, 001 half, 010 word). Any other opcode or funct3 raises neither a request nor a flag.
- R2: The effective address is rs1 plus the sign-extended offset. For loads the offset is insn[31:20]. For stores it is {insn[31:25], insn[11:7]}. mem_addr_o carries address bits [31:2].
- R3: mem_be_o is 0001 shifted left by address bits [1:0] for bytes, 0011 shifted by the same amount for halfwords, and 1111 for words. A store has mem_we_o = 1 and at most 1, 2 or 4 enables set.
- R4: Store data holds the low byte of rs2 repeated in all four lanes for a byte store, and the low halfword in both halves for a halfword store. A word store passes rs2 unchanged.
- R5: A signed byte or halfword load shifts the addressed lane to bit 0 and fills the upper bits with that lane's top bit. A word load returns the word unchanged.
- R6: An unsigned byte or halfword load fills every bit above the loaded field with zero.
- R7: A halfword at an odd address, or a word whose address bits [1:0] are not 00, raises misalign_o and produces no request, no write and no load result.
- R8: After reset all outputs are 0. The request and flag appear in the cycle after valid_i, and last one cycle. With valid_i low, nothing is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction presented this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_i | input | 32 | Base register value |
| rs2_i | input | 32 | Store source register value |
| mem_rdata_i | input | 32 | Word returned by memory for the current request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-steered store data |
| misalign_o | output | 1 | Access was misaligned and dropped |
| rd_valid_o | output | 1 | Load result valid |
| rd_data_o | output | 32 | Extended load result |

## Verification
The hardest cases to reach are those where the offset alone decides the lane and the alignment. These are a negative offset that borrows across a word boundary, and an odd base combined with an odd offset that together land on an aligned halfword. The stimulus reaches them by choosing base and offset pairs whose sum has the wanted low bits, while neither operand has those bits on its own. Sign fill is exercised with a returned word whose top bit differs from lane to lane. The same lane is then read with the signed and the unsigned variant.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  input  logic [31:0] rs1_i,
  input  logic [31:0] rs2_i,
  input  logic [31:0] mem_rdata_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [29:0] mem_addr_o,
  output logic [3:0]  mem_be_o,
  output logic [31:0] mem_wdata_o,
  output logic        misalign_o,
  output logic        rd_valid_o,
  output logic [31:0] rd_data_o
);
  localparam logic [6:0] OPC_LD = 7'b0000011;
  localparam logic [6:0] OPC_ST = 7'b0100011;

  logic [6:0]  opc;
  logic [2:0]  f3;
  logic        is_ld, is_st, hit, misal;
  logic [11:0] ofs;
  logic [31:0] ea;
  logic [3:0]  be;
  logic [31:0] wd;

  assign opc   = insn_i[6:0];
  assign f3    = insn_i[14:12];
  assign is_ld = (opc == OPC_LD) && (f3 != 3'b011) && (f3 != 3'b110) && (f3 != 3'b111);
  assign is_st = (opc == OPC_ST) && !f3[2] && (f3[1:0] != 2'b11);
  assign hit   = valid_i && (is_ld || is_st);
  assign ofs   = is_st ? {insn_i[31:25], insn_i[11:7]} : insn_i[31:20];
  assign ea    = rs1_i + {{20{ofs[11]}}, ofs};
  assign misal = (f3[1:0] == 2'b01 && ea[0]) || (f3[1:0] == 2'b10 && ea[1:0] != 2'b00);

  always_comb begin
    case (f3[1:0])
      2'b00:   begin be = 4'b0001 << ea[1:0]; wd = {4{rs2_i[7:0]}};  end
      2'b01:   begin be = 4'b0011 << ea[1:0]; wd = {2{rs2_i[15:0]}}; end
      default: begin be = 4'b1111;            wd = rs2_i;            end
    endcase
  end

  logic        req_q, we_q, mis_q;
  logic [31:0] addr_q, wd_q;
  logic [2:0]  f3_q;
  logic [3:0]  be_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      mis_q  <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      f3_q   <= '0;
      be_q   <= '0;
    end else begin
      req_q  <= hit && !misal;
      mis_q  <= hit && misal;
      we_q   <= hit && !misal && is_st;
      addr_q <= ea;
      wd_q   <= wd;
      f3_q   <= f3;
      be_q   <= be;
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = req_q ? addr_q[31:2] : '0;
  assign mem_be_o    = req_q ? be_q : 4'b0000;
  assign mem_wdata_o = we_q ? wd_q : '0;
  assign misalign_o  = mis_q;
  assign rd_valid_o  = req_q && !we_q;

  logic [31:0] sh;
  logic [31:0] ext;
  assign sh = mem_rdata_i >> {addr_q[1:0], 3'b000};

  always_comb begin
    case (f3_q)
      3'b000:  ext = {{24{sh[7]}}, sh[7:0]};
      3'b001:  ext = {{16{sh[15]}}, sh[15:0]};
      3'b100:  ext = {24'h0, sh[7:0]};
      3'b101:  ext = {16'h0, sh[15:0]};
      default: ext = sh;
    endcase
  end

  assign rd_data_o = rd_valid_o ? ext : '0;

  assert_half_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && f3_q[1:0] == 2'b01) |-> !addr_q[0]);

  assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && f3_q[1:0] == 2'b10) |-> (addr_q[1:0] == 2'b00));

  assert_store_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 || $countones(mem_be_o) == 4));

  assert_word_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_be_o == 4'hF) |-> (mem_wdata_o == $past(rs2_i)));

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && f3_q == 3'b100) |-> (rd_data_o[31:8] == 24'h0));

  assert_flag_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (mem_be_o == 4'b0000 && !rd_valid_o));
endmodule

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0, rs1_i = '0, rs2_i = '0, mem_rdata_i = '0;
  logic        mem_req_o, mem_we_o, misalign_o, rd_valid_o;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o, rd_data_o;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  lsu_lane_align u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .mem_rdata_i(mem_rdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .misalign_o(misalign_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ld_insn(input logic [2:0] f, input logic [11:0] imm);
    return {imm, 5'd1, f, 5'd2, 7'b0000011};
  endfunction

  function automatic logic [31:0] st_insn(input logic [2:0] f, input logic [11:0] imm);
    return {imm[11:5], 5'd3, 5'd1, f, imm[4:0], 7'b0100011};
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] d, input logic v);
    @(negedge clk);
    insn_i = ins; rs1_i = a; rs2_i = d; valid_i = v;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 reset req", {31'h0, mem_req_o}, 32'h0);
    chk("R8 reset flag", {31'h0, misalign_o}, 32'h0);
    chk("R8 reset be", {28'h0, mem_be_o}, 32'h0);
    chk("R8 reset rd", rd_data_o, 32'h0);
  endtask

  task automatic t_store_bytes;
    for (int k = 0; k < 4; k++) begin
      issue(st_insn(3'b000, 12'(k)), 32'h1000, 32'hAABBCCDD, 1'b1);
      chk("R3 sb be", {28'h0, mem_be_o}, 32'(4'b0001 << k));
      chk("R4 sb data", mem_wdata_o, 32'hDDDDDDDD);
      chk("R2 sb addr", {2'b00, mem_addr_o}, 32'h400);
      chk("R3 sb we", {31'h0, mem_we_o}, 32'h1);
    end
    @(negedge clk);
    chk("R8 one cycle", {31'h0, mem_req_o}, 32'h0);
  endtask

  task automatic t_store_half_word;
    issue(st_insn(3'b001, 12'd1), 32'h1001, 32'h12345678, 1'b1);
    chk("R3 sh be", {28'h0, mem_be_o}, 32'hC);
    chk("R4 sh data", mem_wdata_o, 32'h56785678);
    issue(st_insn(3'b010, 12'hFFC), 32'h1008, 32'hCAFEF00D, 1'b1);
    chk("R2 sw neg ofs addr", {2'b00, mem_addr_o}, 32'h401);
    chk("R3 sw be", {28'h0, mem_be_o}, 32'hF);
    chk("R4 sw data", mem_wdata_o, 32'hCAFEF00D);
    issue(st_insn(3'b010, 12'd2), 32'h1000, 32'h1, 1'b1);
    chk("R7 sw mis flag", {31'h0, misalign_o}, 32'h1);
    chk("R7 sw mis no write", {30'h0, mem_req_o, mem_we_o}, 32'h0);
  endtask

  task automatic t_loads;
    mem_rdata_i = 32'h80F17F22;
    issue(ld_insn(3'b000, 12'd0), 32'h2000, 32'h0, 1'b1);
    chk("R5 lb0", rd_data_o, 32'h00000022);
    chk("R3 lb we low", {31'h0, mem_we_o}, 32'h0);
    issue(ld_insn(3'b000, 12'd1), 32'h2000, 32'h0, 1'b1);
    chk("R5 lb1", rd_data_o, 32'h0000007F);
    issue(ld_insn(3'b000, 12'hFFF), 32'h2003, 32'h0, 1'b1);
    chk("R5 lb2 neg sign", rd_data_o, 32'hFFFFFFF1);
    chk("R2 lb neg ofs addr", {2'b00, mem_addr_o}, 32'h800);
    issue(ld_insn(3'b100, 12'd3), 32'h2000, 32'h0, 1'b1);
    chk("R6 lbu3", rd_data_o, 32'h00000080);
    issue(ld_insn(3'b001, 12'd1), 32'h2001, 32'h0, 1'b1);
    chk("R5 lh2", rd_data_o, 32'hFFFF80F1);
    chk("R3 lh be", {28'h0, mem_be_o}, 32'hC);
    issue(ld_insn(3'b101, 12'd2), 32'h2000, 32'h0, 1'b1);
    chk("R6 lhu2", rd_data_o, 32'h000080F1);
    issue(ld_insn(3'b001, 12'd0), 32'h2000, 32'h0, 1'b1);
    chk("R5 lh0", rd_data_o, 32'h00007F22);
    issue(ld_insn(3'b010, 12'd4), 32'h2000, 32'h0, 1'b1);
    chk("R5 lw", rd_data_o, 32'h80F17F22);
    chk("R3 lw be", {28'h0, mem_be_o}, 32'hF);
    issue(ld_insn(3'b001, 12'd1), 32'h2000, 32'h0, 1'b1);
    chk("R7 lh mis flag", {31'h0, misalign_o}, 32'h1);
    chk("R7 lh mis no load", {31'h0, rd_valid_o}, 32'h0);
  endtask

  task automatic t_ignored;
    issue(ld_insn(3'b011, 12'd0), 32'h2000, 32'h0, 1'b1);
    chk("R1 ld f3 011", {30'h0, mem_req_o, misalign_o}, 32'h0);
    issue(st_insn(3'b100, 12'd0), 32'h2000, 32'h0, 1'b1);
    chk("R1 st f3 100", {30'h0, mem_req_o, misalign_o}, 32'h0);
    issue({7'h0, 5'd3, 5'd1, 3'b000, 5'd2, 7'b0110011}, 32'h2000, 32'h0, 1'b1);
    chk("R1 other opcode", {30'h0, mem_req_o, misalign_o}, 32'h0);
    issue(st_insn(3'b010, 12'd0), 32'h2000, 32'h5, 1'b0);
    chk("R8 no valid", {29'h0, mem_req_o, mem_we_o, misalign_o}, 32'h0);
  endtask

  initial begin
    #(PERIOD*5000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_store_bytes();
    t_store_half_word();
    t_loads();
    t_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule